// File: doc/BRIEF.md
# Four-Mode Barrel Shifter with Carry-Out

This block is a purely combinational shifter for a 32-bit integer datapath. It takes one operand and a shift kind, which is logical left, logical right, arithmetic right or rotate right. It returns the shifted word together with the single bit that a flag unit would latch as the carry.

The shift distance comes from one of two places. The first is a short constant field, in which the all-zero code stands for a distance equal to the full word width. The second is the low byte of a register value. A register distance of zero leaves the operand untouched and forwards the incoming carry flag. Register distances at or beyond the word width follow fixed rules for each shift kind.

The block holds no state. Its outputs settle within the same cycle as its inputs, and the surrounding execute stage samples them.

Top module: `barrel_shifter`

## Requirements
- R1: `shift_kind` is decoded as 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. When `amt_from_reg` is 1, the distance is the low 8 bits of `amt_reg`. When `amt_from_reg` is 0, the distance is `amt_const`, where the code 0 means 32 and the codes 1 to 31 mean themselves.
- R2: A logical left shift by n, with n from 1 to 31, fills the vacated low bits with zeros. The carry-out is operand bit 32-n.
- R3: A logical right shift by n, with n from 1 to 31, fills the vacated high bits with zeros. The carry-out is operand bit n-1.
- R4: An arithmetic right shift by n, with n from 1 to 31, fills the vacated high bits with copies of operand bit 31. The carry-out is operand bit n-1.
- R5: A rotate right by n, where n mod 32 is not zero, reinserts the low bits that leave the word at the top. The carry-out equals result bit 31.
- R6: A distance of exactly 32 gives a result of zero for both logical shifts. The carry-out is operand bit 0 for a left shift and operand bit 31 for a right shift.
- R7: An arithmetic right shift by 32 or more gives 32 copies of operand bit 31. The carry-out is operand bit 31.
- R8: A logical shift in either direction by more than 32 gives zero with a carry-out of 0.
- R9: A rotate by a nonzero distance that is a multiple of 32 returns the operand unchanged, with a carry-out of operand bit 31. Register rotate distances are taken modulo 32.
- R10: A register distance of 0 returns the operand unchanged, with `carry_out` equal to `carry_in`, for every shift kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Operand to shift |
| shift_kind | input | 2 | Shift kind code (see R1) |
| amt_from_reg | input | 1 | 1 selects the register distance, 0 selects the constant field |
| amt_const | input | 5 | Constant distance field, where 0 means 32 |
| amt_reg | input | 8 | Low byte of the register that supplies the distance |
| carry_in | input | 1 | Current carry flag, used for a zero register distance |
| data_out | output | 32 | Shifted result |
| carry_out | output | 1 | Carry produced by the shift |

## Verification
The in-line assertions assume that every input carries a known value. They are skipped while any input is unknown, and every 2-bit kind code is legal, so the assertions need no other premise about the inputs. The stimulus stays inside this premise by driving every input to a defined value from the first cycle onward. Within that premise it sweeps the full range of each input. It uses all 32 constant codes, including the zero code that means 32. It also uses register bytes of 0, 1, 31, 32, 33, 63, 64, 96 and 255, and random bytes across the whole byte range. The operands include words with bit 31 set and words with bit 31 clear, so that the fill and carry rules are exercised on both polarities.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shift_kind_t;
endpackage

// File: rtl/bsh_amount.sv
// Turns the two distance sources into one effective distance and
// classifies it: zero, exactly the width, or beyond the width.
module bsh_amount #(
   parameter int W  = 32,
   parameter int RW = 8,
   localparam int AW = $clog2(W)
) (
   input  logic          from_reg,
   input  logic [AW-1:0] const_amt,
   input  logic [RW-1:0] reg_amt,
   output logic [AW-1:0] low,
   output logic          is_zero,
   output logic          is_exact,
   output logic          is_over
);
   localparam logic [RW-1:0] FULL = RW'(W);

   logic [RW-1:0] eff;

   always_comb begin
      if (from_reg)
         eff = reg_amt;
      else if (const_amt == '0)
         eff = FULL;
      else
         eff = RW'(const_amt);
      low      = eff[AW-1:0];
      is_zero  = (eff == '0);
      is_exact = (eff == FULL);
      is_over  = (eff > FULL);
   end
endmodule

// File: rtl/bsh_rotator.sv
// Logarithmic rotate-right network, one mux rank per distance bit.
module bsh_rotator #(
   parameter int W = 32,
   localparam int AW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);
   logic [W-1:0] rank [0:AW];

   assign rank[0] = din;

   for (genvar g = 0; g < AW; g++) begin : g_rank
      localparam int STEP = 1 << g;
      assign rank[g+1] = amt[g] ? {rank[g][STEP-1:0], rank[g][W-1:STEP]} : rank[g];
   end

   assign dout = rank[AW];
endmodule

// File: rtl/bsh_fixup.sv
// Applies the fill masks and resolves the boundary distances for each shift kind.
module bsh_fixup
   import bsh_pkg::*;
#(
   parameter int W = 32,
   localparam int AW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [W-1:0]  rot,
   input  logic [AW-1:0] low,
   input  logic          is_zero,
   input  logic          is_exact,
   input  logic          is_over,
   input  shift_kind_t   kind,
   input  logic          cin,
   output logic [W-1:0]  dout,
   output logic          cout
);
   logic [W-1:0] keep_r;
   logic [W-1:0] keep_l;
   logic         sign;

   assign keep_r = {W{1'b1}} >> low;
   assign keep_l = {W{1'b1}} << low;
   assign sign   = din[W-1];

   always_comb begin
      dout = rot;
      cout = rot[W-1];
      if (is_zero) begin
         dout = din;
         cout = cin;
      end else begin
         unique case (kind)
            SH_LSL: begin
               if (is_exact) begin
                  dout = '0;
                  cout = din[0];
               end else if (is_over) begin
                  dout = '0;
                  cout = 1'b0;
               end else begin
                  dout = rot & keep_l;
                  cout = rot[0];
               end
            end
            SH_LSR: begin
               if (is_exact) begin
                  dout = '0;
                  cout = sign;
               end else if (is_over) begin
                  dout = '0;
                  cout = 1'b0;
               end else begin
                  dout = rot & keep_r;
                  cout = rot[W-1];
               end
            end
            SH_ASR: begin
               if (is_exact || is_over) begin
                  dout = {W{sign}};
                  cout = sign;
               end else begin
                  dout = (rot & keep_r) | ({W{sign}} & ~keep_r);
                  cout = rot[W-1];
               end
            end
            default: begin
               dout = rot;
               cout = rot[W-1];
            end
         endcase
      end
   end
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
   import bsh_pkg::*;
#(
   parameter int W  = 32,
   parameter int RW = 8,
   localparam int AW = $clog2(W)
) (
   input  logic [W-1:0]  data_in,
   input  logic [1:0]    shift_kind,
   input  logic          amt_from_reg,
   input  logic [AW-1:0] amt_const,
   input  logic [RW-1:0] amt_reg,
   input  logic          carry_in,
   output logic [W-1:0]  data_out,
   output logic          carry_out
);
   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("barrel_shifter: W must be a power of two of at least 2");
   end
   if (RW <= AW) begin : g_bad_reg_width
      $error("barrel_shifter: RW must be wide enough to hold W");
   end

   shift_kind_t   kind;
   logic [AW-1:0] low;
   logic          is_zero, is_exact, is_over;
   logic [AW-1:0] rot_amt;
   logic [W-1:0]  rot;

   assign kind = shift_kind_t'(shift_kind);

   bsh_amount #(.W(W), .RW(RW)) u_amount (
      .from_reg (amt_from_reg),
      .const_amt(amt_const),
      .reg_amt  (amt_reg),
      .low      (low),
      .is_zero  (is_zero),
      .is_exact (is_exact),
      .is_over  (is_over)
   );

   // Left shifts reuse the right rotator by rotating through W minus the distance.
   assign rot_amt = (kind == SH_LSL) ? (AW'(0) - low) : low;

   bsh_rotator #(.W(W)) u_rot (
      .din (data_in),
      .amt (rot_amt),
      .dout(rot)
   );

   bsh_fixup #(.W(W)) u_fix (
      .din     (data_in),
      .rot     (rot),
      .low     (low),
      .is_zero (is_zero),
      .is_exact(is_exact),
      .is_over (is_over),
      .kind    (kind),
      .cin     (carry_in),
      .dout    (data_out),
      .cout    (carry_out)
   );

   logic inputs_known;
   assign inputs_known = !$isunknown({data_in, shift_kind, amt_from_reg, amt_const, amt_reg, carry_in});

   always_comb begin
      if (inputs_known) begin
         if (amt_from_reg && amt_reg == '0) begin
            assert_zero_pass_R10: assert (data_out == data_in && carry_out == carry_in)
               else $error("zero register distance altered operand or carry");
         end
         if (kind == SH_ROR) begin
            assert_rot_keeps_ones_R5: assert ($countones(data_out) == $countones(data_in))
               else $error("rotation changed population count");
         end
         if (kind == SH_ASR) begin
            assert_sign_kept_R4: assert (data_out[W-1] == data_in[W-1])
               else $error("arithmetic shift lost sign");
         end
         if (kind == SH_LSR && !is_zero) begin
            assert_top_cleared_R3: assert (data_out[W-1] == 1'b0)
               else $error("logical right shift left top bit set");
         end
         if ((kind == SH_LSL || kind == SH_LSR) && is_over) begin
            assert_far_shift_zero_R8: assert (data_out == '0 && carry_out == 1'b0)
               else $error("logical shift past width not cleared");
         end
      end
   end
endmodule

// File: tb/tb_barrel_shifter.sv
module tb_barrel_shifter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] data_in = '0;
   logic [1:0]  shift_kind = '0;
   logic        amt_from_reg = 1'b1;
   logic [4:0]  amt_const = '0;
   logic [7:0]  amt_reg = '0;
   logic        carry_in = 1'b0;
   logic [31:0] data_out;
   logic        carry_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   barrel_shifter dut (
      .data_in     (data_in),
      .shift_kind  (shift_kind),
      .amt_from_reg(amt_from_reg),
      .amt_const   (amt_const),
      .amt_reg     (amt_reg),
      .carry_in    (carry_in),
      .data_out    (data_out),
      .carry_out   (carry_out)
   );

   // Behavioural reference built on wide shifts.
   function automatic void model(input logic [31:0] v, input int k, input int n, input logic ci,
                                 output logic [31:0] o, output logic c);
      logic [63:0] t;
      int m;
      if (n == 0) begin
         o = v; c = ci;
         return;
      end
      case (k)
         0: begin
            if (n > 32) begin o = '0; c = 1'b0; end
            else begin t = {32'b0, v} << n; o = t[31:0]; c = t[32]; end
         end
         1: begin
            if (n > 32) begin o = '0; c = 1'b0; end
            else begin t = {v, 32'b0} >> n; o = t[63:32]; c = t[31]; end
         end
         2: begin
            m = (n > 32) ? 32 : n;
            t = $signed({v, 32'b0}) >>> m;
            o = t[63:32]; c = t[31];
         end
         default: begin
            m = n % 32;
            if (m == 0) begin o = v; c = v[31]; end
            else begin o = (v >> m) | (v << (32 - m)); c = o[31]; end
         end
      endcase
   endfunction

   function automatic string tag_of(input int k, input int n, input logic from_reg);
      string s;
      if (n == 0) s = "R10";
      else if (k == 3) s = (n % 32 == 0) ? "R9" : "R5";
      else if (n < 32) s = (k == 0) ? "R2" : (k == 1) ? "R3" : "R4";
      else if (k == 2) s = "R7";
      else if (n == 32) s = "R6";
      else s = "R8";
      if (!from_reg) s = {"R1/", s};
      return s;
   endfunction

   task automatic apply(input logic [31:0] v, input int k, input logic from_reg,
                        input int n, input logic ci);
      logic [31:0] exp_o;
      logic exp_c;
      int eff;
      @(posedge clk);
      #1;
      data_in = v;
      shift_kind = 2'(k);
      amt_from_reg = from_reg;
      carry_in = ci;
      if (from_reg) begin
         amt_reg = 8'(n);
         amt_const = 5'(n);
      end else begin
         amt_const = 5'(n);
         amt_reg = 8'(~n);
      end
      eff = from_reg ? (n & 255) : (((n & 31) == 0) ? 32 : (n & 31));
      model(v, k, eff, ci, exp_o, exp_c);
      @(negedge clk);
      checks++;
      if (data_out !== exp_o || carry_out !== exp_c) begin
         errors++;
         $display("FAIL %s kind=%0d dist=%0d in=%h: data_out=%h expected %h carry_out=%b expected %b",
                  tag_of(k, eff, from_reg), k, eff, v, data_out, exp_o, carry_out, exp_c);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] vals [6];
      int regd [9];
      vals = '{32'h8000_0001, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0000, 32'hA5C3_0F96};
      regd = '{0, 1, 31, 32, 33, 63, 64, 96, 255};
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Quiet state: all-zero inputs with register distance 0 (R10).
      @(negedge clk);
      checks++;
      if (data_out !== 32'h0 || carry_out !== 1'b0) begin
         errors++;
         $display("FAIL R10 idle data_out=%h expected 00000000 carry_out=%b expected 0", data_out, carry_out);
      end
      // R1 constant field: every code, zero code meaning 32 (R6, R7, R9 at code 0).
      for (int vi = 0; vi < 6; vi++)
         for (int k = 0; k < 4; k++)
            for (int c = 0; c < 32; c++)
               apply(vals[vi], k, 1'b0, c, 1'b1);
      // Register distances at and beyond the boundaries (R6 to R10).
      for (int vi = 0; vi < 6; vi++)
         for (int k = 0; k < 4; k++)
            for (int d = 0; d < 9; d++) begin
               apply(vals[vi], k, 1'b1, regd[d], 1'b0);
               apply(vals[vi], k, 1'b1, regd[d], 1'b1);
            end
      // Random operands and distances across the whole byte range (R2 to R5, R8).
      for (int i = 0; i < 4000; i++)
         apply($urandom, $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 255), 1'($urandom));
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule